// File: doc/BRIEF.md
# Pin Wakeup Pattern Detector Bank

This block watches a set of pad inputs while the rest of the chip sleeps and raises a wakeup request when one of them shows a programmed pattern. It runs entirely on a slow always-on clock. A bank of independent detectors each picks one pad, optionally debounces it, and looks for a rising edge, a falling edge, either edge, or a high or low pulse whose width reaches an 8-bit threshold.

A detector that sees its pattern sets its own sticky cause bit. The cause bits stay set until a per-bit clear pulse arrives, and their OR drives the wakeup request. Configuration is presented on plain ports and copied into each detector every cycle. A per-detector lock input freezes that copy until the next reset.

Top module: `pin_wake_bank`

## Requirements
- R1: Each detector takes the pad picked by its select field (pad index, 0 to NUM_PADS-1) after a two-stage synchroniser. With the debounce filter off, an edge-mode match is visible on `cause_o` after the third rising clock edge, counting the edge that first samples the pad change.
- R2: The mode codes are 0 for a rising edge, 1 for a falling edge and 2 for either edge. Codes 5, 6 and 7 never match.
- R3: Mode 3 measures high pulses and mode 4 measures low pulses. The 8-bit counter counts the cycles the detector level spends at the active level, holds at 255, and clears at the opposite level. A match occurs when the level leaves the active level while the count is at or above the threshold.
- R4: With the filter on, the detector level changes only after the synchronised sample has shown the new value for 4 consecutive cycles. Shorter glitches are ignored.
- R5: A match sets that detector's cause bit. The bit stays set through a disable and clears only on its clear pulse. A match in the same cycle as a clear wins.
- R6: `wake_req_o` is high exactly when any cause bit is set.
- R7: A disabled detector never matches, and its pulse counter is held at zero. After re-enabling, counting starts again from zero.
- R8: A change of mode while the detector is enabled does not clear the pulse counter. Cycles at high level counted in an edge mode therefore count toward a later high-pulse match.
- R9: Configuration takes effect one cycle after it is presented. On the cycle a detector's lock input is first high, the configuration presented in that cycle is captured and then held until reset.
- R10: After reset all cause bits are zero and `wake_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pad_i | input | NUM_PADS | Asynchronous pad levels |
| cfg_en_i | input | NUM_DET | Per-detector enable |
| cfg_mode_i | input | 3*NUM_DET | Per-detector pattern code |
| cfg_filt_i | input | NUM_DET | Per-detector debounce enable |
| cfg_sel_i | input | SEL_W*NUM_DET | Per-detector pad index |
| cfg_thr_i | input | CNT_W*NUM_DET | Per-detector pulse threshold |
| cfg_lock_i | input | NUM_DET | Per-detector configuration lock |
| cause_clr_i | input | NUM_DET | Per-bit cause clear pulse |
| cause_o | output | NUM_DET | Sticky cause bits |
| wake_req_o | output | 1 | Wakeup request |

## Verification
The hardest case to reach is the counter carrying over a mode change (R8). To get there, the bench enables a detector in rising-edge mode and holds the pad high for longer than the threshold. It clears the cause bit that the rising edge set and switches to high-pulse mode while the pad is still high. It then drops the pad, so a match can only come from counts gathered before the switch. The saturation case uses a 300-cycle pulse against a threshold of 255. The lock case changes the configuration ports after the lock and shows that the old mode still decides the outcome. A behavioural model compares every cause bit on each cycle.

// File: rtl/pin_wake_pkg.sv
package pin_wake_pkg;
   typedef enum logic [2:0] {
      PW_RISE       = 3'd0,
      PW_FALL       = 3'd1,
      PW_EITHER     = 3'd2,
      PW_HIGH_PULSE = 3'd3,
      PW_LOW_PULSE  = 3'd4
   } pw_mode_e;

   localparam int PW_MODE_W = 3;
endpackage

// File: rtl/pin_wake_sync.sv
module pin_wake_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pin_wake_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pin_wake_filter.sv
module pin_wake_filter #(
   parameter int LEN = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic smp_i,
   output logic level_o
);
   logic level_q;

   generate
      if (LEN < 1) begin : g_bad_len
         $error("pin_wake_filter LEN must be at least one");
      end else if (LEN == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) level_q <= 1'b0;
            else         level_q <= smp_i;
         end
      end else begin : g_hist
         logic [LEN-1:0] hist_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               hist_q  <= '0;
               level_q <= 1'b0;
            end else begin
               hist_q <= {hist_q[LEN-2:0], smp_i};
               if (&hist_q)       level_q <= 1'b1;
               else if (~|hist_q) level_q <= 1'b0;
            end
         end

         // R4: the level moves only after a full run of equal samples
         a_r4_stable_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$stable(level_q) |-> $past((&hist_q) || (~|hist_q)));
      end
   endgenerate

   assign level_o = level_q;
endmodule

// File: rtl/pin_wake_det.sv
module pin_wake_det
   import pin_wake_pkg::*;
#(
   parameter  int NUM_PADS = 16,
   parameter  int CNT_W    = 8,
   parameter  int FILT_LEN = 4,
   localparam int SEL_W    = $clog2(NUM_PADS)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_PADS-1:0]  pads_i,
   input  logic                 en_i,
   input  logic [PW_MODE_W-1:0] mode_i,
   input  logic                 filt_i,
   input  logic [SEL_W-1:0]     sel_i,
   input  logic [CNT_W-1:0]     thr_i,
   input  logic                 lock_i,
   input  logic                 clr_i,
   output logic                 cause_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic                 lock_q, en_q, filt_q;
   logic [PW_MODE_W-1:0] mode_q;
   logic [SEL_W-1:0]     sel_q;
   logic [CNT_W-1:0]     thr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lock_q <= 1'b0;
         en_q   <= 1'b0;
         filt_q <= 1'b0;
         mode_q <= PW_RISE;
         sel_q  <= '0;
         thr_q  <= '0;
      end else begin
         if (lock_i) lock_q <= 1'b1;
         if (!lock_q) begin
            en_q   <= en_i;
            filt_q <= filt_i;
            mode_q <= mode_i;
            sel_q  <= sel_i;
            thr_q  <= thr_i;
         end
      end
   end

   logic sel_smp, filt_lvl, lvl_now, lvl_q, pol, at_pol, hit, cause_q;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      sel_smp = 1'b0;
      if (int'(sel_q) < NUM_PADS) sel_smp = pads_i[sel_q];
   end

   pin_wake_filter #(.LEN(FILT_LEN)) u_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .smp_i   (sel_smp),
      .level_o (filt_lvl)
   );

   assign lvl_now = filt_q ? filt_lvl : sel_smp;
   assign pol     = (mode_q != PW_LOW_PULSE);
   assign at_pol  = (lvl_now == pol);

   always_comb begin
      hit = 1'b0;
      if (en_q) begin
         case (mode_q)
            PW_RISE:       hit = lvl_now & ~lvl_q;
            PW_FALL:       hit = ~lvl_now & lvl_q;
            PW_EITHER:     hit = lvl_now ^ lvl_q;
            PW_HIGH_PULSE,
            PW_LOW_PULSE:  hit = !at_pol && (lvl_q == pol) && (cnt_q >= thr_q);
            default:       hit = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lvl_q   <= 1'b0;
         cnt_q   <= '0;
         cause_q <= 1'b0;
      end else begin
         lvl_q   <= lvl_now;
         cause_q <= hit | (cause_q & ~clr_i);
         if (!en_q)                 cnt_q <= '0;
         else if (!at_pol)          cnt_q <= '0;
         else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cause_o = cause_q;

   // R5: a set cause bit survives every cycle without a clear
   a_r5_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cause_q && !clr_i |=> cause_q);
   // R7: a disabled detector keeps its counter at zero
   a_r7_idle_cnt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q |=> (cnt_q == '0));
   // R7: a disabled detector cannot raise its cause bit
   a_r7_idle_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q && !cause_q |=> !cause_q);
   // R3: the counter holds at its maximum while the level stays active
   a_r3_cnt_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_q && at_pol && (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
   // R9: locked configuration never moves
   a_r9_lock_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_q |=> $stable(en_q) && $stable(mode_q) && $stable(thr_q) && $stable(sel_q) && $stable(filt_q));
   // R2: edge modes need a level change to set the cause bit
   a_r2_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q <= PW_EITHER) && (lvl_now == lvl_q) && !cause_q |=> !cause_q);
endmodule

// File: rtl/pin_wake_bank.sv
module pin_wake_bank
   import pin_wake_pkg::*;
#(
   parameter  int NUM_DET     = 8,
   parameter  int NUM_PADS    = 16,
   parameter  int CNT_W       = 8,
   parameter  int FILT_LEN    = 4,
   parameter  int SYNC_STAGES = 2,
   localparam int SEL_W       = $clog2(NUM_PADS)
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [NUM_PADS-1:0]            pad_i,
   input  logic [NUM_DET-1:0]             cfg_en_i,
   input  logic [NUM_DET*PW_MODE_W-1:0]   cfg_mode_i,
   input  logic [NUM_DET-1:0]             cfg_filt_i,
   input  logic [NUM_DET*SEL_W-1:0]       cfg_sel_i,
   input  logic [NUM_DET*CNT_W-1:0]       cfg_thr_i,
   input  logic [NUM_DET-1:0]             cfg_lock_i,
   input  logic [NUM_DET-1:0]             cause_clr_i,
   output logic [NUM_DET-1:0]             cause_o,
   output logic                           wake_req_o
);
   generate
      if (NUM_PADS < 2) begin : g_bad_pads
         $error("pin_wake_bank needs at least two pads");
      end
      if (NUM_DET < 1) begin : g_bad_det
         $error("pin_wake_bank needs at least one detector");
      end
   endgenerate

   logic [NUM_PADS-1:0] pad_sync;

   pin_wake_sync #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pad_i),
      .q_o    (pad_sync)
   );

   generate
      for (genvar d = 0; d < NUM_DET; d++) begin : g_det
         pin_wake_det #(
            .NUM_PADS (NUM_PADS),
            .CNT_W    (CNT_W),
            .FILT_LEN (FILT_LEN)
         ) u_det (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .pads_i  (pad_sync),
            .en_i    (cfg_en_i[d]),
            .mode_i  (cfg_mode_i[d*PW_MODE_W +: PW_MODE_W]),
            .filt_i  (cfg_filt_i[d]),
            .sel_i   (cfg_sel_i[d*SEL_W +: SEL_W]),
            .thr_i   (cfg_thr_i[d*CNT_W +: CNT_W]),
            .lock_i  (cfg_lock_i[d]),
            .clr_i   (cause_clr_i[d]),
            .cause_o (cause_o[d])
         );
      end
   endgenerate

   assign wake_req_o = |cause_o;

   // R6: a request cannot appear without some cause bit having risen
   a_r6_req_from_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wake_req_o) |-> ($countones(cause_o) > 0));
endmodule

// File: tb/pin_wake_bank_bench.sv
module pin_wake_bank_bench;
   localparam int ND = 8;
   localparam int NP = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pad = '0;
   logic [ND-1:0] en = '0, filt = '0, lock = '0, clr = '0;
   logic [ND*3-1:0] mode = '0;
   logic [ND*4-1:0] sel = '0;
   logic [ND*8-1:0] thr = '0;
   logic [ND-1:0] cause;
   logic          wake;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pin_wake_bank u_pin_wake_bank (
      .clk_i(clk), .rst_ni(rst_n), .pad_i(pad), .cfg_en_i(en), .cfg_mode_i(mode),
      .cfg_filt_i(filt), .cfg_sel_i(sel), .cfg_thr_i(thr), .cfg_lock_i(lock),
      .cause_clr_i(clr), .cause_o(cause), .wake_req_o(wake)
   );

   // behavioural reference
   bit s1 [NP];
   bit s2 [NP];
   bit m_en [ND], m_filt [ND], m_lock [ND], m_lvlf [ND], m_lvlq [ND], m_cause [ND];
   int m_mode [ND], m_sel [ND], m_thr [ND], m_hist [ND], m_cnt [ND];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NP; p++) begin s1[p] = 0; s2[p] = 0; end
         for (int d = 0; d < ND; d++) begin
            m_en[d] = 0; m_filt[d] = 0; m_lock[d] = 0; m_lvlf[d] = 0; m_lvlq[d] = 0;
            m_cause[d] = 0; m_mode[d] = 0; m_sel[d] = 0; m_thr[d] = 0; m_hist[d] = 0; m_cnt[d] = 0;
         end
      end else begin
         for (int d = 0; d < ND; d++) begin
            bit smp, lvl, pl, hit;
            smp = s2[m_sel[d]];
            lvl = m_filt[d] ? m_lvlf[d] : smp;
            pl  = (m_mode[d] != 4);
            hit = 0;
            if (m_en[d]) begin
               if (m_mode[d] == 0) hit = lvl && !m_lvlq[d];
               else if (m_mode[d] == 1) hit = !lvl && m_lvlq[d];
               else if (m_mode[d] == 2) hit = (lvl != m_lvlq[d]);
               else if (m_mode[d] == 3 || m_mode[d] == 4)
                  hit = (lvl != pl) && (m_lvlq[d] == pl) && (m_cnt[d] >= m_thr[d]);
            end
            if (!m_en[d] || lvl != pl) m_cnt[d] = 0;
            else if (m_cnt[d] < 255) m_cnt[d] = m_cnt[d] + 1;
            if (m_hist[d] == 15) m_lvlf[d] = 1;
            else if (m_hist[d] == 0) m_lvlf[d] = 0;
            m_hist[d] = ((m_hist[d] << 1) | int'(smp)) & 15;
            m_lvlq[d] = lvl;
            m_cause[d] = hit || (m_cause[d] && !clr[d]);
            if (!m_lock[d]) begin
               m_en[d] = en[d]; m_filt[d] = filt[d]; m_mode[d] = int'(mode[d*3 +: 3]);
               m_sel[d] = int'(sel[d*4 +: 4]); m_thr[d] = int'(thr[d*8 +: 8]);
            end
            if (lock[d]) m_lock[d] = 1;
         end
         for (int p = 0; p < NP; p++) begin s2[p] = s1[p]; s1[p] = pad[p]; end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         logic [ND-1:0] exp_c;
         for (int d = 0; d < ND; d++) exp_c[d] = m_cause[d];
         checks++;
         if (cause !== exp_c) begin
            errors++;
            $display("FAIL R5 per-cycle cause: actual %b expected %b", cause, exp_c);
         end
         checks++;
         if (wake !== (|exp_c)) begin
            errors++;
            $display("FAIL R6 per-cycle request: actual %b expected %b", wake, |exp_c);
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_clr(input logic [ND-1:0] m);
      clr = m; idle(1); clr = '0;
   endtask

   task automatic set_det(input int d, input bit e, input int md, input bit f, input int s, input int t);
      en[d] = e; mode[d*3 +: 3] = 3'(md); filt[d] = f; sel[d*4 +: 4] = 4'(s); thr[d*8 +: 8] = 8'(t);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      chk("R10 cause after reset", 64'(cause), 64'h0);
      chk("R10 request after reset", 64'(wake), 64'h0);

      set_det(0, 1, 0, 0, 3, 0);
      set_det(1, 1, 1, 0, 3, 0);
      set_det(2, 1, 2, 0, 3, 0);
      set_det(3, 1, 5, 0, 3, 0);
      idle(3);
      pad[3] = 1; idle(6);
      chk("R1 rising edge on selected pad", 64'(cause[0]), 64'h1);
      chk("R2 falling mode ignores rise", 64'(cause[1]), 64'h0);
      chk("R2 either mode sees rise", 64'(cause[2]), 64'h1);
      chk("R6 request raised", 64'(wake), 64'h1);
      pulse_clr('1); idle(2);
      chk("R5 clear pulse empties causes", 64'(cause), 64'h0);
      pad[3] = 0; idle(6);
      chk("R2 fall seen, code 5 silent", 64'(cause[3:0]), 64'h6);
      en[2] = 0; idle(3);
      chk("R5 cause held while disabled", 64'(cause[2]), 64'h1);
      en[0] = 0; pad[3] = 1; idle(6);
      chk("R7 disabled detector silent", 64'(cause[0]), 64'h0);
      pulse_clr('1); en[3:0] = '0; idle(2);

      set_det(4, 1, 2, 1, 5, 0); idle(8);
      pad[5] = 1; idle(3); pad[5] = 0; idle(12);
      chk("R4 short glitch filtered", 64'(cause[4]), 64'h0);
      pad[5] = 1; idle(12);
      chk("R4 stable level accepted", 64'(cause[4]), 64'h1);

      set_det(5, 1, 3, 0, 6, 5);
      pad[7] = 1; idle(4);
      set_det(6, 1, 4, 0, 7, 3); idle(3);
      pad[6] = 1; idle(4); pad[6] = 0; idle(6);
      chk("R3 high pulse below threshold", 64'(cause[5]), 64'h0);
      pad[6] = 1; idle(5); pad[6] = 0; idle(6);
      chk("R3 high pulse at threshold", 64'(cause[5]), 64'h1);
      pad[7] = 0; idle(2); pad[7] = 1; idle(6);
      chk("R3 low pulse below threshold", 64'(cause[6]), 64'h0);
      pad[7] = 0; idle(3); pad[7] = 1; idle(6);
      chk("R3 low pulse at threshold", 64'(cause[6]), 64'h1);
      pulse_clr('1);
      thr[5*8 +: 8] = 8'd255; idle(2);
      pad[6] = 1; idle(300); pad[6] = 0; idle(6);
      chk("R3 saturated count meets 255", 64'(cause[5]), 64'h1);

      pulse_clr('1);
      set_det(5, 1, 0, 0, 6, 10); idle(2);
      pad[6] = 1; idle(12);
      pulse_clr(8'h20); idle(1);
      chk("R5 cleared while level high", 64'(cause[5]), 64'h0);
      mode[5*3 +: 3] = 3'd3; idle(3);
      pad[6] = 0; idle(6);
      chk("R8 count kept across mode change", 64'(cause[5]), 64'h1);
      pulse_clr('1); idle(2);
      pad[6] = 1; idle(12);
      en[5] = 0; idle(2); en[5] = 1; idle(2);
      pad[6] = 0; idle(6);
      chk("R7 disable restarts count", 64'(cause[5]), 64'h0);

      set_det(7, 1, 0, 0, 8, 0); lock[7] = 1; idle(1);
      lock[7] = 0; mode[7*3 +: 3] = 3'd1; en[7] = 0; idle(2);
      pad[8] = 1; idle(6);
      chk("R9 locked rising mode still active", 64'(cause[7]), 64'h1);
      pulse_clr(8'h80); pad[8] = 0; idle(6);
      chk("R9 locked mode ignores fall", 64'(cause[7]), 64'h0);

      idle(3);
      finish_run();
   end
endmodule